// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a three-wire link to a two-channel, 12-bit successive-approximation converter. On a start request it selects the converter, waits for it to wake, and generates a divided serial clock that idles low. It shifts in a 16-bit frame on rising clock edges and then deselects the converter. The frame has three leading marker bits, a channel-identity bit and twelve data bits, MSB first. The block presents the data word, the channel bit and a frame-error flag together with a one-cycle `done` pulse. It then keeps chip-select high for a minimum gap before it will accept another start.

Two conversion-clock modes are supported, chosen per request by `int_mode`. In the external mode the serial clock itself paces the conversion, so chip-select falls while the clock is low. In the internal mode the clock is raised first and chip-select falls while it is high. After the wake time a single falling edge starts the conversion. The block then polls the data line for the end-of-conversion marker and reads the frame only after it appears. If the marker does not come within a limit, the attempt is abandoned and `timed_out` pulses. Every timing interval is a parameter counted in system-clock cycles.

Top module: `sar_serial_reader`

## Requirements
- R1: In external mode (`int_mode`=0 at start) chip-select falls while `sclk` is low, and `sclk` is never high while chip-select is high.
- R2: After chip-select falls, the first `sclk` edge comes no sooner than WAKE_CYC system cycles later.
- R3: A completed frame has exactly 16 rising `sclk` edges while selected, and every high phase of those clocks lasts HALF_DIV cycles.
- R4: The frame is captured on rising `sclk` edges. Bits 1 to 3 are the leading markers, bit 4 goes to `chan_id`, and bits 5 to 16 go to `result[11:0]`, most significant first.
- R5: Chip-select rises only after the 16th falling `sclk` edge, and `done` pulses for one cycle on the cycle chip-select rises.
- R6: Chip-select stays high at least DESEL_CYC cycles between frames. A `start` that arrives while `busy` is high is ignored and opens no extra frame.
- R7: In internal mode chip-select falls while `sclk` is high. After the wake time one falling edge is issued, and no rising edge follows until `sdi` reads 1.
- R8: `frame_err` is 1 exactly when any of the three leading bits was 0. The result and channel are still delivered with `done`.
- R9: In internal mode, if `sdi` stays 0 for EOC_LIMIT cycles after the first falling edge, chip-select rises, `timed_out` pulses for one cycle, no rising edge has been issued and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame (taken only while idle) |
| int_mode | input | 1 | 1 selects the converter's internal conversion clock |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | High from an accepted start until the idle state returns |
| done | output | 1 | One-cycle pulse when a frame result is presented |
| timed_out | output | 1 | One-cycle pulse when an internal-mode wait is abandoned |
| result | output | 12 | Captured conversion data |
| chan_id | output | 1 | Captured channel-identity bit |
| frame_err | output | 1 | A leading marker bit was 0 |

## Verification
The bench builds the block with HALF_DIV=2, WAKE_CYC=5, DESEL_CYC=3 and EOC_LIMIT=60. These short intervals let a few dozen randomly mixed external- and internal-mode frames run in a small number of cycles. With conversion delays of up to 30 cycles, every normal internal-mode frame finishes well inside the limit. Turning the end-of-conversion marker off in the converter model then drives the timeout path to its end. The small divider also makes every clock phase short enough that each one can be measured and checked exactly.

// File: rtl/sar_serial_reader.sv
module sar_serial_reader #(
  parameter int HALF_DIV   = 50,
  parameter int WAKE_CYC   = 500,
  parameter int DESEL_CYC  = 12,
  parameter int EOC_LIMIT  = 2000,
  parameter int FRAME_BITS = 16,
  parameter int DATA_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              int_mode,
  input  logic              sdi,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              done,
  output logic              timed_out,
  output logic [DATA_W-1:0] result,
  output logic              chan_id,
  output logic              frame_err
);
  localparam int LEAD = FRAME_BITS - DATA_W - 1;
  localparam int M1   = (HALF_DIV > WAKE_CYC) ? HALF_DIV : WAKE_CYC;
  localparam int M2   = (DESEL_CYC > EOC_LIMIT) ? DESEL_CYC : EOC_LIMIT;
  localparam int CMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(FRAME_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_WAKE, S_POLL, S_HI, S_LO, S_DESEL} st_t;

  st_t                   st;
  logic [CW-1:0]         cnt;
  logic [BW-1:0]         bits;
  logic [FRAME_BITS-1:0] shreg;
  logic                  mode_q;

  wire tick = (cnt == '0);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bits <= '0; shreg <= '0; mode_q <= 1'b0;
      cs_n <= 1'b1; sclk <= 1'b0; done <= 1'b0; timed_out <= 1'b0;
      result <= '0; chan_id <= 1'b0; frame_err <= 1'b0;
    end else begin
      done <= 1'b0;
      timed_out <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= int_mode;
          bits   <= '0;
          if (int_mode) begin
            st <= S_PREP; sclk <= 1'b1; cnt <= CW'(HALF_DIV - 1);
          end else begin
            st <= S_WAKE; cs_n <= 1'b0; cnt <= CW'(WAKE_CYC - 1);
          end
        end
        S_PREP: if (tick) begin
          st <= S_WAKE; cs_n <= 1'b0; cnt <= CW'(WAKE_CYC - 1);
        end
        S_WAKE: if (tick) begin
          if (mode_q) begin
            st <= S_POLL; sclk <= 1'b0; cnt <= CW'(EOC_LIMIT - 1);
          end else begin
            st <= S_HI; sclk <= 1'b1; shreg <= {shreg[FRAME_BITS-2:0], sdi};
            cnt <= CW'(HALF_DIV - 1);
          end
        end
        S_POLL: begin
          if (sdi) begin
            st <= S_HI; sclk <= 1'b1; shreg <= {shreg[FRAME_BITS-2:0], sdi};
            cnt <= CW'(HALF_DIV - 1);
          end else if (tick) begin
            st <= S_DESEL; cs_n <= 1'b1; timed_out <= 1'b1;
            cnt <= CW'(DESEL_CYC - 1);
          end
        end
        S_HI: if (tick) begin
          st <= S_LO; sclk <= 1'b0; bits <= bits + 1'b1; cnt <= CW'(HALF_DIV - 1);
        end
        S_LO: if (tick) begin
          if (bits == BW'(FRAME_BITS)) begin
            st <= S_DESEL; cs_n <= 1'b1; done <= 1'b1;
            result    <= shreg[DATA_W-1:0];
            chan_id   <= shreg[DATA_W];
            frame_err <= ~&shreg[FRAME_BITS-1 -: LEAD];
            cnt <= CW'(DESEL_CYC - 1);
          end else begin
            st <= S_HI; sclk <= 1'b1; shreg <= {shreg[FRAME_BITS-2:0], sdi};
            cnt <= CW'(HALF_DIV - 1);
          end
        end
        S_DESEL: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_EXT_SEL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && !mode_q) |-> !sclk); // R1
  AST_CLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (!cs_n || st == S_PREP)); // R1
  AST_INT_SEL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && mode_q) |-> sclk); // R7
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bits <= BW'(FRAME_BITS)); // R3
  AST_DONE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n)); // R5
  AST_TIMEOUT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (!done && $rose(cs_n) && bits == '0)); // R9
endmodule

// File: tb/sim_sar_serial_reader.sv
module sim_sar_serial_reader;
  localparam int DIV = 2, WAKE = 5, DESEL = 3, LIMIT = 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, int_mode = 1'b0, sdi = 1'b0;
  logic cs_n, sclk, busy, done, timed_out, chan_id, frame_err;
  logic [11:0] result;

  sar_serial_reader #(.HALF_DIV(DIV), .WAKE_CYC(WAKE), .DESEL_CYC(DESEL),
    .EOC_LIMIT(LIMIT), .FRAME_BITS(16), .DATA_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .int_mode(int_mode), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done), .timed_out(timed_out),
    .result(result), .chan_id(chan_id), .frame_err(frame_err));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, frames = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [15:0] f);
    return ~&f[15:13];
  endfunction

  // converter model
  logic [15:0] m_frame = '0;
  bit m_eoc_en = 1'b1, m_wait = 1'b0, m_conv = 1'b0, mp_cs = 1'b1, mp_sclk = 1'b0;
  int m_idx = 0, m_cnt = 0, m_delay = 5;

  always @(negedge clk) begin
    if (cs_n) begin
      sdi = 1'b0; m_wait = 1'b0; m_conv = 1'b0;
    end else if (mp_cs) begin
      m_idx = 0;
      if (sclk) begin m_wait = 1'b1; m_conv = 1'b0; sdi = 1'b0; end
      else sdi = m_frame[15];
    end else if (mp_sclk && !sclk) begin
      if (m_wait && !m_conv) begin m_conv = 1'b1; m_cnt = m_delay; end
      else if (!m_wait) begin
        m_idx++;
        sdi = (m_idx < 16) ? m_frame[15-m_idx] : 1'b0;
      end
    end
    if (!cs_n && m_wait && m_conv) begin
      if (m_cnt == 0) begin
        if (m_eoc_en) begin sdi = 1'b1; m_wait = 1'b0; m_idx = 0; end
      end else m_cnt--;
    end
    mp_cs = cs_n; mp_sclk = sclk;
  end

  // link monitor
  bit exp_int = 1'b0, exp_to = 1'b0, pcs = 1'b1, psclk = 1'b0, first = 1'b0, seen_rise = 1'b0;
  int since_fall = 0, rises = 0, run = 0, cs_hi = 0, cs_falls = 0;

  always @(negedge clk) if (rst_n) begin
    if (pcs && !cs_n) begin
      cs_falls++;
      chk(sclk == exp_int, exp_int ? "R7 clock high at select" : "R1 clock low at select", sclk, exp_int);
      if (seen_rise) chk(cs_hi + 1 >= DESEL, "R6 deselect gap", cs_hi + 1, DESEL);
      since_fall = 0; first = 1'b0; rises = 0;
    end else if (!cs_n) since_fall++;
    if (!cs_n && !pcs && sclk != psclk) begin
      if (!first) begin
        first = 1'b1;
        chk(since_fall >= WAKE, "R2 wake wait", since_fall, WAKE);
      end else if (!sclk) chk(run == DIV, "R3 high phase", run, DIV);
      if (sclk) rises++;
    end
    if (cs_n && sclk && !(exp_int && busy)) chk(1'b0, "R1 clock high while deselected", 1, 0);
    if (!pcs && cs_n) begin
      cs_hi = 0; seen_rise = 1'b1;
      chk(rises == (exp_to ? 0 : 16), "R3 rising edges per frame", rises, exp_to ? 0 : 16);
      chk(done == !exp_to, "R5 done at deselect", done, !exp_to);
      chk(timed_out == exp_to, "R9 timeout pulse", timed_out, exp_to);
    end else if (cs_n) cs_hi++;
    if (done && !(cs_n && !pcs)) chk(1'b0, "R5 done without deselect", 1, 0);
    run = (sclk != psclk) ? 1 : run + 1;
    pcs = cs_n; psclk = sclk;
  end

  task automatic run_frame(input bit im, input logic [2:0] lead, input bit ch,
                           input logic [11:0] d, input int dly, input bit eoc, input bit poke);
    logic [15:0] f;
    int w;
    f = {lead, ch, d};
    if (im) f[15] = 1'b1;
    m_frame = f; m_delay = dly; m_eoc_en = eoc;
    exp_int = im; exp_to = !eoc;
    @(negedge clk); start = 1'b1; int_mode = im;
    @(negedge clk); start = 1'b0;
    frames++;
    w = 0;
    while (!done && !timed_out && w < 2000) begin
      @(negedge clk); w++;
      if (poke && w == 20) start = 1'b1;
      if (poke && w == 21) start = 1'b0;
    end
    if (eoc) begin
      chk(done, "R5 frame completed", done, 1);
      chk(result == d, "R4 data word", result, d);
      chk(chan_id == ch, "R4 channel bit", chan_id, ch);
      chk(frame_err == exp_err(f), "R8 frame error flag", frame_err, exp_err(f));
    end else begin
      chk(timed_out && !done, "R9 abandoned without result", done, 0);
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset deselected", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset clock low", sclk, 0);
    chk(!busy && !done && !timed_out, "R5 reset idle", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 3'b111, 1'b0, 12'h000, 0, 1, 0);
    run_frame(0, 3'b111, 1'b1, 12'hFFF, 0, 1, 0);
    run_frame(1, 3'b111, 1'b1, 12'hA5C, 12, 1, 0);
    run_frame(0, 3'b011, 1'b0, 12'h123, 0, 1, 0);
    run_frame(1, 3'b101, 1'b0, 12'h800, 4, 1, 0);
    run_frame(0, 3'b110, 1'b1, 12'h001, 0, 1, 1);
    run_frame(1, 3'b111, 1'b0, 12'h7FE, 1, 1, 1);
    run_frame(1, 3'b111, 1'b0, 12'h3C3, 0, 0, 0);
    for (int i = 0; i < 24; i++) begin
      logic [2:0] ld;
      ld = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b111;
      run_frame(1'($urandom), ld, 1'($urandom), 12'($urandom), $urandom_range(0, 30), 1, 1'($urandom));
    end
    run_frame(0, 3'b111, 1'b1, 12'h5A5, 0, 1, 0);
    chk(cs_falls == frames, "R6 start ignored while busy", cs_falls, frames);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(1'b0, "watchdog", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule